// File: doc/BRIEF.md
# Hybrid Strict-Priority / Weighted Round-Robin Queue Scheduler

This block chooses which of eight transmit queues of an egress channel sends next. Each channel has a 3-bit mode code that splits its eight queues into two groups. The upper-index queues are served in strict priority, with the highest index first. The lower-index queues share the remaining service by deficit-weighted round robin. The codes range from all-WRR to all-strict. Per-queue 16-bit weights are loaded through one indexed command word. Software polls a completion bit before it issues the next command. A per-queue close bit removes a queue from arbitration.

A requester presents a channel number, that channel's eight not-empty flags and the packet length. The block answers with a completion pulse, a grant-valid flag and the granted queue index. WRR deficits are charged by the packet length. The scheduling FSM has four states:
- S_IDLE accepts a request and moves to S_PICK.
- S_PICK moves to S_DONE when it grants or when no queue is eligible. It moves to S_REFILL when the chosen WRR queue has no credit left.
- S_REFILL adds the queue weight and returns to S_PICK.
- S_DONE returns to S_IDLE.

The weight loader has two states. W_IDLE moves to W_APPLY when a strobed command arrives. W_APPLY writes the weight and returns to W_IDLE.

Top module: `hsq_top`

## Requirements
- R1: After reset every channel mode reads 1 (all strict), all close bits read 0, all weights are 0, the weight status word reads 0x4000_0000, `cfg_err`, `gnt_done` and `sched_busy` are 0.
- R2: Mode writes (`reg_wr_sel`=1) hold channels 8·idx..8·idx+7 in one word. Channel c uses bits 4·(c mod 8)+2 .. 4·(c mod 8). The fourth bit of each nibble is dropped and reads 0.
- R3: A split request (`reg_wr_sel`=3) carries the channel in data bits 12:8 and a strict-queue count n in bits 3:0. The count maps to a mode as follows: n=0 gives mode 0, n=1..6 gives mode n+1, and n=8 gives mode 1. An accepted request clears `cfg_err`.
- R4: A split request with n=7 or n>8 leaves every mode unchanged and sets `cfg_err`. The flag also reads as bit 0 when `reg_rd_sel`=3.
- R5: A weight command (`reg_wr_sel`=0) is taken only when bit 31 is set. Its fields are channel in bits 23:19, queue in bits 18:16 and weight in bits 15:0. The status word reads these fields back. A write without bit 31 changes nothing.
- R6: Status bit 30 reads 0 in the cycle after a command is accepted and reads 1 one cycle later, once the weight is stored. Commands that arrive while bit 30 is 0 are ignored.
- R7: The close bit for channel c, queue q sits at bit q+8·(c mod 4) of close word c/4 (`reg_wr_sel`=2). A closed queue is never granted. Clearing the bit makes the queue eligible again.
- R8: For a mode whose WRR width is k (mode 0 gives 8, mode 1 gives 0, mode m≥2 gives 9−m), queues k..7 are strict. The highest eligible strict queue always wins over any WRR queue.
- R9: With unit-length packets, a WRR queue of weight w receives w consecutive grants before rotation moves to the next eligible queue in ascending index order, wrapping. A weight of 0 acts as 1.
- R10: A request is accepted only while `sched_busy` is 0. Each request ends with exactly one `gnt_done` pulse. If no open non-empty queue exists, `gnt_valid` is 0 at that pulse.
- R11: A grant subtracts the packet length from the queue's deficit. Once the deficit is ≤0 the rotation moves on. Reaching a queue whose deficit is ≤0 costs one refill (deficit += weight) per two extra cycles until it is positive. The grant latency is 2+2·refills clock edges from acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Write target: 0 weight cmd, 1 mode, 2 close, 3 split request |
| reg_wr_idx | input | 3 | Word index for mode and close writes |
| reg_wr_data | input | 32 | Write data |
| reg_rd_sel | input | 2 | Readback target, same encoding |
| reg_rd_idx | input | 3 | Readback word index |
| reg_rd_data | output | 32 | Readback data |
| cfg_err | output | 1 | Last split request was rejected |
| req_valid | input | 1 | Grant request strobe |
| req_chan | input | 5 | Channel of the request |
| req_not_empty | input | 8 | Not-empty flags of that channel's queues |
| req_len | input | 16 | Packet length charged to WRR deficit |
| sched_busy | output | 1 | Request in progress |
| gnt_done | output | 1 | One-cycle completion pulse |
| gnt_valid | output | 1 | A queue was granted |
| gnt_queue | output | 3 | Granted queue index |

## Verification
The assertions check several properties on every cycle:
- A grant only names a queue that was open and non-empty when the decision was made.
- A strict grant never passes over a higher eligible queue.
- The completion pulse is one cycle wide and always follows a decision.
- A refill always returns to a decision.
- The weight status bit drops and recovers in two cycles.
- A rejected split leaves all modes untouched.

The bench scenarios show the rest: the mode field layout, the count-to-mode mapping, the grant order across many mode and close combinations, the weighted run lengths, and the refill latency driven by packet length.

// File: rtl/hsq_pkg.sv
package hsq_pkg;
    localparam int NQ = 8;
    localparam int QW = 3;

    typedef enum logic [1:0] {
        SEL_WEIGHT = 2'd0,
        SEL_MODE   = 2'd1,
        SEL_CLOSE  = 2'd2,
        SEL_SPLIT  = 2'd3
    } reg_sel_e;

    // number of WRR queues selected by a mode code
    function automatic logic [3:0] wrr_width(input logic [2:0] m);
        case (m)
            3'd0:    return 4'd8;
            3'd1:    return 4'd0;
            default: return 4'd9 - {1'b0, m};
        endcase
    endfunction
endpackage

// File: rtl/hsq_cfg.sv
module hsq_cfg
    import hsq_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [2:0]           wr_idx,
    input  logic [31:0]          wr_data,
    input  logic [1:0]           rd_sel,
    input  logic [2:0]           rd_idx,
    output logic [31:0]          rd_data,
    output logic                 cfg_err,
    output logic [NUM_CH*3-1:0]  mode_flat,
    output logic [NUM_CH*NQ-1:0] close_flat
);
    localparam int CLOSE_WORDS = NUM_CH / 4;

    logic [2:0]           mode_q [NUM_CH];
    logic [NUM_CH*NQ-1:0] close_q;
    logic                 err_q;
    logic [4:0]           split_ch;
    logic [3:0]           split_n;
    logic                 split_ok;
    logic [2:0]           split_mode;
    logic                 split_wr;

    assign split_ch = wr_data[12:8];
    assign split_n  = wr_data[3:0];
    assign split_ok = (split_n <= 4'd8) && (split_n != 4'd7) && (int'(split_ch) < NUM_CH);
    assign split_wr = wr_en && (wr_sel == SEL_SPLIT);

    always_comb begin
        if (split_n == 4'd0)      split_mode = 3'd0;
        else if (split_n == 4'd8) split_mode = 3'd1;
        else                      split_mode = split_n[2:0] + 3'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) mode_q[c] <= 3'd1;
            close_q <= '0;
            err_q   <= 1'b0;
        end else if (wr_en) begin
            if (wr_sel == SEL_MODE) begin
                for (int c = 0; c < NUM_CH; c++)
                    if (3'(c / 8) == wr_idx) mode_q[c] <= wr_data[(c % 8)*4 +: 3];
            end
            if (wr_sel == SEL_CLOSE) begin
                for (int w = 0; w < CLOSE_WORDS; w++)
                    if (3'(w) == wr_idx) close_q[w*32 +: 32] <= wr_data;
            end
            if (split_wr) begin
                err_q <= !split_ok;
                if (split_ok) mode_q[split_ch[$clog2(NUM_CH)-1:0]] <= split_mode;
            end
        end
    end

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) mode_flat[c*3 +: 3] = mode_q[c];
    end
    assign close_flat = close_q;
    assign cfg_err    = err_q;

    always_comb begin
        rd_data = '0;
        unique case (reg_sel_e'(rd_sel))
            SEL_MODE: begin
                for (int c = 0; c < NUM_CH; c++)
                    if (3'(c / 8) == rd_idx) rd_data[(c % 8)*4 +: 3] = mode_q[c];
            end
            SEL_CLOSE: begin
                for (int w = 0; w < CLOSE_WORDS; w++)
                    if (3'(w) == rd_idx) rd_data = close_q[w*32 +: 32];
            end
            SEL_SPLIT:  rd_data = {31'd0, err_q};
            SEL_WEIGHT: rd_data = '0;
        endcase
    end

    // R4: rejected split keeps every mode and raises the flag
    p_reject_keeps_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (split_wr && !split_ok) |=> (cfg_err && mode_flat == $past(mode_flat)));
    // R3: accepted split clears the flag
    p_accept_clears_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (split_wr && split_ok) |=> !cfg_err);
endmodule

// File: rtl/hsq_wload.sv
module hsq_wload
    import hsq_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int WT_W   = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_wr,
    input  logic [24:0]               cmd_data,   // {strobe, chan[4:0], queue[2:0], weight[15:0]}
    input  logic [$clog2(NUM_CH)-1:0] rd_ch,
    input  logic [QW-1:0]             rd_q,
    output logic [WT_W-1:0]           rd_wt,
    output logic [31:0]               stat_word
);
    localparam int CH_W = $clog2(NUM_CH);

    typedef enum logic {W_IDLE, W_APPLY} wst_e;

    wst_e            state, state_nx;
    logic [WT_W-1:0] wt_q [NUM_CH][NQ];
    logic [4:0]      lat_ch;
    logic [QW-1:0]   lat_q;
    logic [15:0]     lat_val;
    logic            take;

    assign take = cmd_wr && cmd_data[24] && (state == W_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= W_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            W_IDLE:  if (take) state_nx = W_APPLY;
            W_APPLY: state_nx = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_ch  <= '0;
            lat_q   <= '0;
            lat_val <= '0;
            for (int c = 0; c < NUM_CH; c++)
                for (int q = 0; q < NQ; q++) wt_q[c][q] <= '0;
        end else begin
            if (take) begin
                lat_ch  <= cmd_data[23:19];
                lat_q   <= cmd_data[18:16];
                lat_val <= cmd_data[15:0];
            end
            if (state == W_APPLY && int'(lat_ch) < NUM_CH)
                wt_q[lat_ch[CH_W-1:0]][lat_q] <= lat_val[WT_W-1:0];
        end
    end

    assign rd_wt     = wt_q[rd_ch][rd_q];
    assign stat_word = {1'b0, (state == W_IDLE), 6'd0, lat_ch, lat_q, lat_val};

    // R6: accepted command makes status busy for exactly one cycle
    p_pending_after_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !stat_word[30]);
    p_apply_completes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_word[30] |=> stat_word[30]);
    // R5: no strobe, no change
    p_no_strobe_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !cmd_data[24] && state == W_IDLE) |=> (stat_word[30] && $stable(lat_val)));
endmodule

// File: rtl/hsq_arb.sv
module hsq_arb
    import hsq_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int WT_W   = 16,
    parameter int LEN_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [$clog2(NUM_CH)-1:0] req_chan,
    input  logic [NQ-1:0]             req_ne,
    input  logic [LEN_W-1:0]          req_len,
    input  logic [NUM_CH*3-1:0]       mode_flat,
    input  logic [NUM_CH*NQ-1:0]      close_flat,
    input  logic [WT_W-1:0]           wt,
    output logic [$clog2(NUM_CH)-1:0] wt_ch,
    output logic [QW-1:0]             wt_q,
    output logic                      busy,
    output logic                      gnt_done,
    output logic                      gnt_valid,
    output logic [QW-1:0]             gnt_queue
);
    localparam int CH_W  = $clog2(NUM_CH);
    localparam int DEF_W = ((WT_W > LEN_W) ? WT_W : LEN_W) + 2;

    typedef enum logic [1:0] {S_IDLE, S_PICK, S_REFILL, S_DONE} sst_e;

    sst_e                    state, state_nx;
    logic [CH_W-1:0]         cap_ch;
    logic [NQ-1:0]           cap_ne;
    logic [LEN_W-1:0]        cap_len;
    logic [QW-1:0]           rq;
    logic                    gv_q;
    logic [QW-1:0]           gq_q;
    logic [QW-1:0]           ptr_q [NUM_CH];
    logic signed [DEF_W-1:0] def_q [NUM_CH][NQ];

    logic [3:0]              nwrr;
    logic [NQ-1:0]           strict_m, elig, s_hit, w_hit;
    logic [QW-1:0]           s_pick, w_pick, ptr_cur, idx;
    logic signed [DEF_W-1:0] cur_def, after, weff;
    logic                    cur_pos, after_pos;

    always_comb begin
        nwrr = wrr_width(mode_flat[int'(cap_ch)*3 +: 3]);
        for (int i = 0; i < NQ; i++) strict_m[i] = (i >= int'(nwrr));
        elig  = cap_ne & ~close_flat[int'(cap_ch)*NQ +: NQ];
        s_hit = elig & strict_m;
        w_hit = elig & ~strict_m;
        s_pick = '0;
        for (int i = 0; i < NQ; i++) if (s_hit[i]) s_pick = QW'(i);
        ptr_cur = ptr_q[cap_ch];
        w_pick  = '0;
        for (int k = NQ-1; k >= 0; k--) begin
            idx = ptr_cur + QW'(k);
            if (w_hit[idx]) w_pick = idx;
        end
        cur_def   = def_q[cap_ch][w_pick];
        after     = cur_def - $signed({{(DEF_W-LEN_W){1'b0}}, cap_len});
        cur_pos   = cur_def > 0;
        after_pos = after > 0;
        weff      = $signed({{(DEF_W-WT_W){1'b0}}, ((wt == '0) ? WT_W'(1) : wt)});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (req_valid) state_nx = S_PICK;
            S_PICK: begin
                if (|s_hit)                 state_nx = S_DONE;
                else if (|w_hit && !cur_pos) state_nx = S_REFILL;
                else                        state_nx = S_DONE;
            end
            S_REFILL: state_nx = S_PICK;
            S_DONE:   state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_ch  <= '0;
            cap_ne  <= '0;
            cap_len <= '0;
            rq      <= '0;
            gv_q    <= 1'b0;
            gq_q    <= '0;
            for (int c = 0; c < NUM_CH; c++) begin
                ptr_q[c] <= '0;
                for (int q = 0; q < NQ; q++) def_q[c][q] <= '0;
            end
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    cap_ch  <= req_chan;
                    cap_ne  <= req_ne;
                    cap_len <= req_len;
                end
                S_PICK: begin
                    if (|s_hit) begin
                        gv_q <= 1'b1;
                        gq_q <= s_pick;
                    end else if (|w_hit) begin
                        if (cur_pos) begin
                            gv_q <= 1'b1;
                            gq_q <= w_pick;
                            def_q[cap_ch][w_pick] <= after;
                            if (!after_pos) ptr_q[cap_ch] <= w_pick + QW'(1);
                        end else begin
                            rq <= w_pick;
                        end
                    end else begin
                        gv_q <= 1'b0;
                    end
                end
                S_REFILL: def_q[cap_ch][rq] <= def_q[cap_ch][rq] + weff;
                S_DONE: ;
            endcase
        end
    end

    always_comb begin
        busy      = (state != S_IDLE);
        gnt_done  = (state == S_DONE);
        gnt_valid = gv_q;
        gnt_queue = gq_q;
        wt_ch     = cap_ch;
        wt_q      = rq;
    end

    // R7: a granted queue was open and non-empty at the decision
    p_grant_eligible_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_done && gnt_valid) |-> (((8'($past(elig)) >> gnt_queue) & 8'd1) != 8'd0));
    // R8: a strict grant never skips a higher eligible queue
    p_strict_highest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_done && gnt_valid && $past(|s_hit)) |-> (((8'($past(elig)) >> gnt_queue) >> 1) == 8'd0));
    // R10: completion pulse follows a decision and lasts one cycle
    p_done_after_pick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_done |-> ($past(state) == S_PICK));
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_done |=> !gnt_done);
    // R11: a refill always goes back to a decision
    p_refill_returns_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_REFILL) |=> (state == S_PICK));
endmodule

// File: rtl/hsq_top.sv
module hsq_top
    import hsq_pkg::*;
#(
    parameter int NUM_CH = 32,
    parameter int WT_W   = 16,
    parameter int LEN_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr_en,
    input  logic [1:0]                reg_wr_sel,
    input  logic [2:0]                reg_wr_idx,
    input  logic [31:0]               reg_wr_data,
    input  logic [1:0]                reg_rd_sel,
    input  logic [2:0]                reg_rd_idx,
    output logic [31:0]               reg_rd_data,
    output logic                      cfg_err,
    input  logic                      req_valid,
    input  logic [$clog2(NUM_CH)-1:0] req_chan,
    input  logic [NQ-1:0]             req_not_empty,
    input  logic [LEN_W-1:0]          req_len,
    output logic                      sched_busy,
    output logic                      gnt_done,
    output logic                      gnt_valid,
    output logic [QW-1:0]             gnt_queue
);
    localparam int CH_W = $clog2(NUM_CH);

    logic [31:0]          cfg_rd, wl_stat;
    logic [NUM_CH*3-1:0]  mode_flat;
    logic [NUM_CH*NQ-1:0] close_flat;
    logic [WT_W-1:0]      wt;
    logic [CH_W-1:0]      wt_ch;
    logic [QW-1:0]        wt_q;

    hsq_cfg #(.NUM_CH(NUM_CH)) cfg_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .wr_sel(reg_wr_sel), .wr_idx(reg_wr_idx), .wr_data(reg_wr_data),
        .rd_sel(reg_rd_sel), .rd_idx(reg_rd_idx), .rd_data(cfg_rd),
        .cfg_err(cfg_err), .mode_flat(mode_flat), .close_flat(close_flat)
    );

    hsq_wload #(.NUM_CH(NUM_CH), .WT_W(WT_W)) wload_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(reg_wr_en && (reg_wr_sel == SEL_WEIGHT)),
        .cmd_data({reg_wr_data[31], reg_wr_data[23:0]}),
        .rd_ch(wt_ch), .rd_q(wt_q), .rd_wt(wt), .stat_word(wl_stat)
    );

    hsq_arb #(.NUM_CH(NUM_CH), .WT_W(WT_W), .LEN_W(LEN_W)) arb_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_chan(req_chan), .req_ne(req_not_empty), .req_len(req_len),
        .mode_flat(mode_flat), .close_flat(close_flat), .wt(wt),
        .wt_ch(wt_ch), .wt_q(wt_q),
        .busy(sched_busy), .gnt_done(gnt_done), .gnt_valid(gnt_valid), .gnt_queue(gnt_queue)
    );

    assign reg_rd_data = (reg_rd_sel == SEL_WEIGHT) ? wl_stat : cfg_rd;
endmodule

// File: tb/hsq_tb.sv
module hsq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_sel = '0;
    logic [2:0]  reg_wr_idx = '0;
    logic [31:0] reg_wr_data = '0;
    logic [1:0]  reg_rd_sel = '0;
    logic [2:0]  reg_rd_idx = '0;
    logic [31:0] reg_rd_data;
    logic        cfg_err;
    logic        req_valid = 1'b0;
    logic [4:0]  req_chan = '0;
    logic [7:0]  req_not_empty = '0;
    logic [15:0] req_len = '0;
    logic        sched_busy, gnt_done, gnt_valid;
    logic [2:0]  gnt_queue;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    hsq_top dut_i (.*);

    // {mode[22:20], close[19:12], not_empty[11:4], exp_valid[3], exp_queue[2:0]}
    localparam logic [22:0] VEC [12] = '{
        {3'd1, 8'h00, 8'h16, 1'b1, 3'd4},
        {3'd1, 8'h00, 8'h00, 1'b0, 3'd0},
        {3'd1, 8'h10, 8'h16, 1'b1, 3'd2},
        {3'd0, 8'h00, 8'h08, 1'b1, 3'd3},
        {3'd2, 8'h00, 8'h81, 1'b1, 3'd7},
        {3'd2, 8'h80, 8'h81, 1'b1, 3'd0},
        {3'd7, 8'h00, 8'h23, 1'b1, 3'd5},
        {3'd7, 8'h00, 8'h02, 1'b1, 3'd1},
        {3'd4, 8'h00, 8'h50, 1'b1, 3'd6},
        {3'd4, 8'h40, 8'h50, 1'b1, 3'd4},
        {3'd1, 8'hFF, 8'hFF, 1'b0, 3'd0},
        {3'd6, 8'h00, 8'h0C, 1'b1, 3'd3}
    };

    localparam logic [2:0] WRR_SEQ [9] = '{3'd0, 3'd0, 3'd0, 3'd1, 3'd2, 3'd2, 3'd0, 3'd0, 3'd0};

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [2:0] idx, input logic [31:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_idx = idx; reg_wr_data = data;
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, input logic [2:0] idx, output logic [31:0] data);
        reg_rd_sel = sel; reg_rd_idx = idx;
        #1;
        data = reg_rd_data;
    endtask

    task automatic wcmd(input logic [4:0] ch, input logic [2:0] q, input logic [15:0] w);
        wr(2'd0, 3'd0, {1'b1, 7'd0, ch, q, w});
        @(negedge clk);
    endtask

    task automatic req(input logic [4:0] ch, input logic [7:0] ne, input logic [15:0] len,
                       output logic v, output logic [2:0] q, output int cyc, output logic bsy);
        @(negedge clk);
        req_valid = 1'b1; req_chan = ch; req_not_empty = ne; req_len = len;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        bsy = sched_busy;
        cyc = 1;
        while (!gnt_done && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
        v = gnt_valid; q = gnt_queue;
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic        v, bsy;
        logic [2:0]  q;
        int          cyc;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd1, 3'd0, d); chk(d == 32'h1111_1111, "R1 mode word", d, 32'h1111_1111);
        rd(2'd2, 3'd3, d); chk(d == 32'h0, "R1 close word", d, 32'h0);
        rd(2'd0, 3'd0, d); chk(d == 32'h4000_0000, "R1 weight status", d, 32'h4000_0000);
        chk(!gnt_done && !sched_busy && !cfg_err, "R1 outputs idle",
            {29'd0, gnt_done, sched_busy, cfg_err}, 32'h0);

        // R2 mode word layout, top nibble bit dropped
        wr(2'd1, 3'd2, 32'hFEDC_BA98);
        rd(2'd1, 3'd2, d); chk(d == 32'h7654_3210, "R2 mode readback", d, 32'h7654_3210);

        // R3 split mapping on channel 9 (word 1, bits 6:4)
        wr(2'd3, 3'd0, 32'h0000_0900);
        rd(2'd1, 3'd1, d); chk(d[6:4] == 3'd0, "R3 count0", {29'd0, d[6:4]}, 32'd0);
        wr(2'd3, 3'd0, 32'h0000_0903);
        rd(2'd1, 3'd1, d); chk(d[6:4] == 3'd4, "R3 count3", {29'd0, d[6:4]}, 32'd4);
        wr(2'd3, 3'd0, 32'h0000_0908);
        rd(2'd1, 3'd1, d); chk(d[6:4] == 3'd1, "R3 count8", {29'd0, d[6:4]}, 32'd1);
        wr(2'd3, 3'd0, 32'h0000_0906);
        rd(2'd1, 3'd1, d); chk(d[6:4] == 3'd7, "R3 count6", {29'd0, d[6:4]}, 32'd7);

        // R4 reject count 7 and 9
        wr(2'd3, 3'd0, 32'h0000_0907);
        rd(2'd1, 3'd1, d); chk(d[6:4] == 3'd7, "R4 mode kept", {29'd0, d[6:4]}, 32'd7);
        chk(cfg_err, "R4 err set", {31'd0, cfg_err}, 32'd1);
        rd(2'd3, 3'd0, d); chk(d == 32'd1, "R4 err readback", d, 32'd1);
        wr(2'd3, 3'd0, 32'h0000_0909);
        rd(2'd1, 3'd1, d); chk(d == 32'h1111_1171, "R4 word kept", d, 32'h1111_1171);
        wr(2'd3, 3'd0, 32'h0000_0902);
        rd(2'd1, 3'd1, d); chk(d[6:4] == 3'd3 && !cfg_err, "R3 count2 clears err",
                               {28'd0, cfg_err, d[6:4]}, 32'd3);

        // R5 / R6 weight command handshake
        wr(2'd0, 3'd0, {1'b1, 7'd0, 5'd3, 3'd2, 16'd2});
        rd(2'd0, 3'd0, d); chk(d[30] == 1'b0, "R6 done low while pending", {31'd0, d[30]}, 32'd0);
        @(negedge clk);
        rd(2'd0, 3'd0, d);
        chk(d == 32'h401A_0002, "R5 R6 status after apply", d, 32'h401A_0002);
        wr(2'd0, 3'd0, {1'b0, 7'd0, 5'd3, 3'd2, 16'd9});
        @(negedge clk);
        rd(2'd0, 3'd0, d); chk(d == 32'h401A_0002, "R5 no strobe ignored", d, 32'h401A_0002);

        // table walk on channel 5: R7 R8 R10
        for (int i = 0; i < 12; i++) begin
            wr(2'd1, 3'd0, (32'h1111_1111 & ~(32'hF << 20)) | (32'(VEC[i][22:20]) << 20));
            wr(2'd2, 3'd1, 32'(VEC[i][19:12]) << 8);
            req(5'd5, VEC[i][11:4], 16'd1, v, q, cyc, bsy);
            chk(v == VEC[i][3], $sformatf("R8 R7 R10 vec%0d valid", i), {31'd0, v}, {31'd0, VEC[i][3]});
            if (VEC[i][3])
                chk(q == VEC[i][2:0], $sformatf("R8 R7 vec%0d queue", i), {29'd0, q}, {29'd0, VEC[i][2:0]});
        end
        wr(2'd2, 3'd1, 32'h0);
        req(5'd5, 8'h80, 16'd1, v, q, cyc, bsy);
        chk(v && q == 3'd7, "R7 reopened queue granted", {28'd0, v, q}, 32'hF);
        chk(bsy, "R10 busy after accept", {31'd0, bsy}, 32'd1);

        // R9 weighted run lengths on channel 3, weight 0 acts as 1
        wr(2'd3, 3'd0, 32'h0000_0300);
        wcmd(5'd3, 3'd0, 16'd3);
        wcmd(5'd3, 3'd1, 16'd0);
        for (int i = 0; i < 9; i++) begin
            req(5'd3, 8'h07, 16'd1, v, q, cyc, bsy);
            chk(v && q == WRR_SEQ[i], $sformatf("R9 grant %0d", i), {28'd0, v, q}, {28'd1, WRR_SEQ[i]});
        end

        // R11 packet-length deficit and refill latency on channel 4
        wr(2'd3, 3'd0, 32'h0000_0400);
        wcmd(5'd4, 3'd0, 16'd4);
        wcmd(5'd4, 3'd1, 16'd4);
        req(5'd4, 8'h03, 16'd10, v, q, cyc, bsy);
        chk(q == 3'd0 && cyc == 4, "R11 long pkt q0 one refill", {q, 29'(cyc)}, {3'd0, 29'd4});
        req(5'd4, 8'h03, 16'd1, v, q, cyc, bsy);
        chk(q == 3'd1 && cyc == 4, "R11 rotate to q1", {q, 29'(cyc)}, {3'd1, 29'd4});
        req(5'd4, 8'h03, 16'd3, v, q, cyc, bsy);
        chk(q == 3'd1 && cyc == 2, "R11 q1 credit left", {q, 29'(cyc)}, {3'd1, 29'd2});
        req(5'd4, 8'h03, 16'd1, v, q, cyc, bsy);
        chk(q == 3'd0 && cyc == 6, "R11 q0 two refills", {q, 29'(cyc)}, {3'd0, 29'd6});

        finish_run();
    end
endmodule